// File: doc/BRIEF.md
# Prioritized Interrupt Service Core

This block arbitrates among eight interrupt request lines for a processor. Each line is synchronized to the core clock and then captured into a pending register, either on a rising transition or, when configured for level sensing, for as long as the line stays high. A mask register gates individual lines. An in-service register records levels the processor is currently handling, so that only strictly more urgent requests can interrupt it. A rotating priority pointer lets software make all levels equal in urgency or pick any level as the least urgent.

The processor raises `ack` for one cycle to claim the current winner. The claimed level moves from pending to in-service, and its number is held on `ack_lvl` until the next claim. Software retires in-service levels with end-of-service commands issued on `cmd_valid`/`cmd_op`/`cmd_lvl`. Some of these commands also rotate priority, and one only sets it. A special mask setting lets masked in-service levels stop blocking other levels. An automatic end-of-service setting retires a claim at once, and it can optionally rotate priority on every claim.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, `int_o` is low and level 0 is the most urgent, with urgency decreasing towards level 7.
- R2: With `cfg_level`=0 a line sets its pending bit on the third rising clock edge after it goes high. A line that stays high does not request again after its claim. A line that goes low clears its pending bit.
- R3: With `cfg_level`=1 the pending bit follows the synchronized line. It is cleared for one cycle by a claim and sets again if the line is still high.
- R4: `mask_we` loads `mask_wdata` into the mask register at the next edge. A mask bit of 1 keeps that level from raising `int_o` or being claimed, while its pending bit is still recorded. Other levels are not affected.
- R5: `int_o` is high exactly when the most urgent unmasked pending level is strictly more urgent than the most urgent blocking in-service level, or when no in-service level blocks.
- R6: When `ack` is sampled while `int_o` is high, the winning level's in-service bit is set, its pending bit is cleared, `ack_lvl` shows the level and `ack_valid` is 1 from the next edge.
- R7: When `ack` is sampled while `int_o` is low, `ack_lvl` becomes 7, `ack_valid` becomes 0, and the in-service register is unchanged.
- R8: `cmd_op`=1 (general end-of-service) clears the most urgent blocking in-service bit.
- R9: `cmd_op`=2 (targeted end-of-service) clears the in-service bit numbered by `cmd_lvl`.
- R10: `cmd_op`=3 acts as R8 and then makes the cleared level the least urgent. `cmd_op`=4 acts as R9 and makes `cmd_lvl` the least urgent. `cmd_op`=5 only makes `cmd_lvl` the least urgent. In each case the next level, modulo 8, becomes the most urgent. Other codes do nothing.
- R11: With `cfg_smm`=1, in-service bits whose mask bit is set block no level, and `cmd_op`=1 or 3 skips them.
- R12: With `cfg_aeoi`=1 a claim sets no in-service bit. If `cfg_rot_aeoi`=1 as well, the claimed level becomes the least urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Asynchronous request lines |
| cfg_level | input | 1 | 1 = level sensing, 0 = rising-transition sensing |
| cfg_smm | input | 1 | Special mask setting |
| cfg_aeoi | input | 1 | Automatic end-of-service on claim |
| cfg_rot_aeoi | input | 1 | Rotate priority on each automatic end-of-service |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R8 to R10) |
| cmd_lvl | input | 3 | Level operand of a command |
| ack | input | 1 | Claim strobe from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| ack_lvl | output | 3 | Level given by the most recent claim |
| ack_valid | output | 1 | 1 if the most recent claim found an eligible level |
| irr_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |

## Verification
Several properties assume that a claim and a command never arrive in the same cycle. The effect of one on the in-service register would otherwise hide the effect of the other. The stimulus keeps `ack` and `cmd_valid` apart in every phase, including the random one, while mask writes and configuration changes may land at any time. The request lines change only between clock edges and are held for several cycles, so each transition reaches the pending register through the synchronizer as the model expects.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_EOI_NS   = 3'd1,
    CMD_EOI_SPEC = 3'd2,
    CMD_ROT_NS   = 3'd3,
    CMD_ROT_SPEC = 3'd4,
    CMD_SET_PRIO = 3'd5
  } cmd_e;
endpackage

// File: rtl/irq_req_front.sv
module irq_req_front #(
  parameter int NLVL = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_in,
  output logic [NLVL-1:0] lvl_o,
  output logic [NLVL-1:0] rise_o
);
  // per line: synchronizer chain plus one extra stage for transition detect
  for (genvar g = 0; g < NLVL; g++) begin : g_line
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], irq_in[g]};
    end
    assign lvl_o[g]  = sh[SYNC_STAGES-1];
    assign rise_o[g] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] vec,
  input  logic [LW-1:0]   top,
  output logic            found,
  output logic [LW-1:0]   idx,
  output logic [LW-1:0]   rank
);
  // level sitting at urgency rank r when 'top' is most urgent
  function automatic logic [LW-1:0] lvl_at(input logic [LW-1:0] t, input int r);
    return t + LW'(r);
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int r = NLVL - 1; r >= 0; r--) begin
      if (vec[lvl_at(top, r)]) begin
        found = 1'b1;
        idx   = lvl_at(top, r);
        rank  = LW'(r);
      end
    end
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_in,
  input  logic            cfg_level,
  input  logic            cfg_smm,
  input  logic            cfg_aeoi,
  input  logic            cfg_rot_aeoi,
  input  logic            mask_we,
  input  logic [NLVL-1:0] mask_wdata,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [LW-1:0]   cmd_lvl,
  input  logic            ack,
  output logic            int_o,
  output logic [LW-1:0]   ack_lvl,
  output logic            ack_valid,
  output logic [NLVL-1:0] irr_o,
  output logic [NLVL-1:0] isr_o,
  output logic [NLVL-1:0] imr_o
);
  localparam logic [LW-1:0] DEFAULT_LVL = LW'(NLVL - 1);

  function automatic logic [NLVL-1:0] onehot(input logic [LW-1:0] i);
    logic [NLVL-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  logic [NLVL-1:0] irr_q, isr_q, imr_q;
  logic [LW-1:0]   top_q;
  logic [LW-1:0]   ack_lvl_q;
  logic            ack_valid_q;

  logic [NLVL-1:0] req_lvl, req_rise;
  irq_req_front #(.NLVL(NLVL), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_o(req_lvl), .rise_o(req_rise)
  );

  // candidates and blocking in-service set
  logic [NLVL-1:0] cand_vec, blk_vec;
  assign cand_vec = irr_q & ~imr_q;
  assign blk_vec  = cfg_smm ? (isr_q & ~imr_q) : isr_q;

  logic            c_found, b_found;
  logic [LW-1:0]   c_idx, c_rank, b_idx, b_rank;
  irq_prio_pick #(.NLVL(NLVL)) u_pick_req (
    .vec(cand_vec), .top(top_q), .found(c_found), .idx(c_idx), .rank(c_rank)
  );
  irq_prio_pick #(.NLVL(NLVL)) u_pick_blk (
    .vec(blk_vec), .top(top_q), .found(b_found), .idx(b_idx), .rank(b_rank)
  );

  // named events
  logic            eligible, grant;
  logic [NLVL-1:0] grant_vec, isr_set, eoi_clr;
  logic            cmd_ns, cmd_sp, cmd_lvl_rot, cmd_ns_rot, aeoi_rot;
  cmd_e            op;

  assign eligible  = c_found && (!b_found || (c_rank < b_rank));
  assign grant     = ack && eligible;
  assign grant_vec = grant ? onehot(c_idx) : '0;
  assign isr_set   = (grant && !cfg_aeoi) ? onehot(c_idx) : '0;

  assign op          = cmd_e'(cmd_op);
  assign cmd_ns      = cmd_valid && (op == CMD_EOI_NS   || op == CMD_ROT_NS);
  assign cmd_sp      = cmd_valid && (op == CMD_EOI_SPEC || op == CMD_ROT_SPEC);
  assign cmd_lvl_rot = cmd_valid && (op == CMD_ROT_SPEC || op == CMD_SET_PRIO);
  assign cmd_ns_rot  = cmd_valid && (op == CMD_ROT_NS) && b_found;
  assign aeoi_rot    = grant && cfg_aeoi && cfg_rot_aeoi;
  assign eoi_clr     = ((cmd_ns && b_found) ? onehot(b_idx) : '0)
                     | (cmd_sp ? onehot(cmd_lvl) : '0);

  logic [NLVL-1:0] irr_d, isr_d;
  logic [LW-1:0]   top_d;

  always_comb begin
    if (cfg_level) irr_d = req_lvl & ~grant_vec;
    else           irr_d = req_lvl & (req_rise | (irr_q & ~grant_vec));
    isr_d = (isr_q & ~eoi_clr) | isr_set;
    if (cmd_lvl_rot)     top_d = cmd_lvl + LW'(1);
    else if (cmd_ns_rot) top_d = b_idx + LW'(1);
    else if (aeoi_rot)   top_d = c_idx + LW'(1);
    else                 top_d = top_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q       <= '0;
      isr_q       <= '0;
      imr_q       <= '0;
      top_q       <= '0;
      ack_lvl_q   <= '0;
      ack_valid_q <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      top_q <= top_d;
      if (mask_we) imr_q <= mask_wdata;
      if (ack) begin
        ack_lvl_q   <= grant ? c_idx : DEFAULT_LVL;
        ack_valid_q <= grant;
      end
    end
  end

  assign int_o     = eligible;
  assign ack_lvl   = ack_lvl_q;
  assign ack_valid = ack_valid_q;
  assign irr_o     = irr_q;
  assign isr_o     = isr_q;
  assign imr_o     = imr_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [LW-1:0]   cmd_lvl,
  input logic            mask_we,
  input logic [NLVL-1:0] mask_wdata,
  input logic            cfg_aeoi,
  input logic            int_o,
  input logic [LW-1:0]   ack_lvl,
  input logic            ack_valid,
  input logic [NLVL-1:0] irr_o,
  input logic [NLVL-1:0] isr_o,
  input logic [NLVL-1:0] imr_o
);
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> imr_o == $past(mask_wdata));

  p_int_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (irr_o & ~imr_o) != '0);

  p_claim_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_o) |=> ack_valid);

  p_claim_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_o && !cfg_aeoi && !cmd_valid) |=> isr_o[ack_lvl]);

  p_default_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_o) |=> (!ack_valid && ack_lvl == LW'(NLVL - 1)));

  p_default_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_o && !cmd_valid) |=> $stable(isr_o));

  p_spec_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !ack) |=> !isr_o[$past(cmd_lvl)]);

  p_aeoi_isr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cfg_aeoi && !cmd_valid) |=> $stable(isr_o));
endmodule

bind irq_prio_core irq_prio_core_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_lvl(cmd_lvl), .mask_we(mask_we), .mask_wdata(mask_wdata), .cfg_aeoi(cfg_aeoi),
  .int_o(int_o), .ack_lvl(ack_lvl), .ack_valid(ack_valid),
  .irr_o(irr_o), .isr_o(isr_o), .imr_o(imr_o)
);

// File: tb/test_irq_prio_core.sv
`timescale 1ns/1ps
module test_irq_prio_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_level = 0, cfg_smm = 0, cfg_aeoi = 0, cfg_rot_aeoi = 0;
  logic       mask_we = 0;
  logic [7:0] mask_wdata = '0;
  logic       cmd_valid = 0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_lvl = '0;
  logic       ack = 0;
  logic       int_o, ack_valid;
  logic [2:0] ack_lvl;
  logic [7:0] irr_o, isr_o, imr_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_core i_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_level(cfg_level), .cfg_smm(cfg_smm),
    .cfg_aeoi(cfg_aeoi), .cfg_rot_aeoi(cfg_rot_aeoi), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lvl(cmd_lvl),
    .ack(ack), .int_o(int_o), .ack_lvl(ack_lvl), .ack_valid(ack_valid),
    .irr_o(irr_o), .isr_o(isr_o), .imr_o(imr_o)
  );

  // ---------------- behavioural reference ----------------
  bit [7:0] m_s1, m_s2, m_s3, m_irr, m_isr, m_imr;
  int       m_top, m_alvl;
  bit       m_aval;

  // returns the most urgent set level of v (or -1), with its rank
  function automatic int most_urgent(bit [7:0] v, int t, output int rank);
    rank = 99;
    for (int r = 0; r < 8; r++) begin
      if (v[(t + r) % 8]) begin
        rank = r;
        return (t + r) % 8;
      end
    end
    return -1;
  endfunction

  function automatic int ref_winner();
    int cr, br, cl, bl;
    bit [7:0] blk;
    blk = cfg_smm ? (m_isr & ~m_imr) : m_isr;
    cl = most_urgent(m_irr & ~m_imr, m_top, cr);
    bl = most_urgent(blk, m_top, br);
    if (cl >= 0 && (bl < 0 || cr < br)) return cl;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irr = 0; m_isr = 0; m_imr = 0;
      m_top = 0; m_alvl = 0; m_aval = 0;
    end else begin
      int w, bl, br;
      bit [7:0] n_irr, n_isr, blk;
      int n_top;
      w   = ref_winner();
      blk = cfg_smm ? (m_isr & ~m_imr) : m_isr;
      bl  = most_urgent(blk, m_top, br);
      for (int i = 0; i < 8; i++) begin
        bit got;
        got = ack && (w == i);
        if (cfg_level) n_irr[i] = m_s2[i] && !got;
        else n_irr[i] = m_s2[i] && ((m_s2[i] && !m_s3[i]) || (m_irr[i] && !got));
      end
      n_isr = m_isr;
      n_top = m_top;
      if (cmd_valid && (cmd_op == 1 || cmd_op == 3) && bl >= 0) n_isr[bl] = 0;
      if (cmd_valid && (cmd_op == 2 || cmd_op == 4)) n_isr[cmd_lvl] = 0;
      if (ack && w >= 0 && !cfg_aeoi) n_isr[w] = 1;
      if (cmd_valid && (cmd_op == 4 || cmd_op == 5)) n_top = (cmd_lvl + 1) % 8;
      else if (cmd_valid && cmd_op == 3 && bl >= 0) n_top = (bl + 1) % 8;
      else if (ack && w >= 0 && cfg_aeoi && cfg_rot_aeoi) n_top = (w + 1) % 8;
      if (ack) begin
        m_aval = (w >= 0);
        m_alvl = (w >= 0) ? w : 7;
      end
      if (mask_we) m_imr = mask_wdata;
      m_irr = n_irr; m_isr = n_isr; m_top = n_top;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model comparison every cycle, mid-period
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3 pending", irr_o, m_irr);
      chk("R6 in-service", isr_o, m_isr);
      chk("R4 mask", imr_o, m_imr);
      chk("R5 int", int_o, (ref_winner() >= 0));
      chk("R7 ack_lvl", ack_lvl, m_alvl);
      chk("R6 ack_valid", ack_valid, m_aval);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic do_ack();
    ack = 1; step(1); ack = 0;
  endtask
  task automatic do_cmd(int op, int lvl);
    cmd_valid = 1; cmd_op = 3'(op); cmd_lvl = 3'(lvl); step(1); cmd_valid = 0;
  endtask
  task automatic do_mask(int v);
    mask_we = 1; mask_wdata = 8'(v); step(1); mask_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 irr", irr_o, 0); chk("R1 isr", isr_o, 0);
    chk("R1 imr", imr_o, 0); chk("R1 int", int_o, 0);

    // R2 edge capture, claim, no re-request
    irq_in[3] = 1; step(3);
    chk("R2 irr", irr_o, 8'h08); chk("R5 int", int_o, 1);
    do_ack();
    chk("R6 isr", isr_o, 8'h08); chk("R6 irr", irr_o, 0);
    chk("R6 lvl", ack_lvl, 3); chk("R6 valid", ack_valid, 1);
    step(5);
    chk("R2 held", irr_o, 0);
    do_cmd(1, 0);
    chk("R8 ns eoi", isr_o, 0);
    irq_in = 0; step(3);

    // R5 nesting
    irq_in[5] = 1; step(3); do_ack();
    irq_in[6] = 1; step(3);
    chk("R5 lower blocked", int_o, 0);
    irq_in[2] = 1; step(3);
    chk("R5 higher", int_o, 1);
    do_ack();
    chk("R6 nested", isr_o, 8'h24); chk("R6 lvl2", ack_lvl, 2);
    do_cmd(1, 0);
    chk("R8 most urgent", isr_o, 8'h20);
    do_cmd(2, 5);
    chk("R9 spec", isr_o, 8'h00); chk("R9 int", int_o, 1);
    do_ack(); chk("R6 lvl6", ack_lvl, 6);
    do_cmd(2, 6);
    irq_in = 0; step(3);

    // R7 default claim
    do_ack();
    chk("R7 lvl", ack_lvl, 7); chk("R7 valid", ack_valid, 0); chk("R7 isr", isr_o, 0);

    // R4 masking
    do_mask(8'h01);
    irq_in[0] = 1; step(3);
    chk("R4 recorded", irr_o, 8'h01); chk("R4 no int", int_o, 0);
    do_ack();
    chk("R4 no claim", ack_valid, 0); chk("R4 still pending", irr_o, 8'h01);
    do_mask(0);
    chk("R4 unmask", int_o, 1);
    do_ack(); chk("R4 lvl0", ack_lvl, 0);
    do_cmd(1, 0);
    irq_in = 0; step(3);

    // R3 level mode
    cfg_level = 1;
    irq_in[4] = 1; step(3);
    chk("R3 irr", irr_o, 8'h10);
    do_ack();
    chk("R3 cleared", irr_o, 0);
    step(1);
    chk("R3 re-set", irr_o, 8'h10);
    do_cmd(1, 0);
    irq_in = 0; step(3);
    chk("R3 drop", irr_o, 0);
    cfg_level = 0;

    // R10 rotations
    do_cmd(5, 5);
    irq_in[0] = 1; irq_in[7] = 1; step(3);
    do_ack(); chk("R10 set prio", ack_lvl, 7);
    do_cmd(3, 0);
    chk("R10 rot ns clr", isr_o, 0);
    do_ack(); chk("R10 after rot", ack_lvl, 0);
    do_cmd(4, 0);
    chk("R10 rot spec", isr_o, 0);
    irq_in = 0; step(3);
    irq_in[0] = 1; irq_in[1] = 1; step(3);
    do_ack(); chk("R10 top1", ack_lvl, 1);
    do_cmd(4, 1);
    irq_in = 0; step(3);
    do_cmd(5, 7);

    // R11 special mask
    irq_in[2] = 1; step(3); do_ack();
    do_mask(8'h04);
    irq_in[5] = 1; step(3);
    chk("R11 normal blocks", int_o, 0);
    cfg_smm = 1; step(1);
    chk("R11 smm allows", int_o, 1);
    do_ack(); chk("R11 lvl5", ack_lvl, 5); chk("R11 isr", isr_o, 8'h24);
    do_cmd(1, 0);
    chk("R11 ns skips masked", isr_o, 8'h04);
    do_cmd(2, 2);
    cfg_smm = 0; do_mask(0);
    irq_in = 0; step(3);

    // R12 automatic end-of-service with rotation
    cfg_aeoi = 1; cfg_rot_aeoi = 1;
    irq_in[1] = 1; step(3);
    do_ack(); chk("R12 lvl", ack_lvl, 1); chk("R12 isr", isr_o, 0);
    irq_in[0] = 1; irq_in[3] = 1; step(3);
    do_ack(); chk("R12 rotated", ack_lvl, 3);
    cfg_aeoi = 0; cfg_rot_aeoi = 0;
    irq_in = 0; step(3);
    do_cmd(5, 7);

    // random phase, model compared every cycle
    for (int c = 0; c < 1500; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 5) == 0) irq_in[$urandom_range(0, 7)] ^= 1'b1;
      if ($urandom_range(0, 60) == 0) cfg_level = ~cfg_level;
      if ($urandom_range(0, 60) == 0) cfg_smm = ~cfg_smm;
      if ($urandom_range(0, 80) == 0) cfg_aeoi = ~cfg_aeoi;
      if ($urandom_range(0, 80) == 0) cfg_rot_aeoi = ~cfg_rot_aeoi;
      mask_we = ($urandom_range(0, 19) == 0);
      mask_wdata = 8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255));
      ack = (r < 12);
      cmd_valid = (r >= 12 && r < 24);
      cmd_op = 3'($urandom_range(0, 7));
      cmd_lvl = 3'($urandom_range(0, 7));
      step(1);
    end
    ack = 0; cmd_valid = 0; mask_we = 0;
    step(2);
    finish_run();
  end
endmodule